// File: doc/BRIEF.md
# Bunch-Crossing Trigger Message Assembler

The block builds the trigger word that goes to the detectors on every bunch crossing. It keeps a crossing counter and an orbit counter. An orbit pulse resets the crossing counter and advances the orbit counter. Between pulses the crossing counter wraps at a programmable orbit length.

Each crossing may carry an interaction flag. The input pattern and an event-type code arrive with that flag. The block holds all three in delay lines and emits three separate decisions for each interaction, at 31, 60 and 256 crossings after it. These are the three latency classes. Every detector is assigned to one class, or to none. A decision reaches a detector only if the detector belongs to that class and is not busy in the crossing where the decision is made. The block introduces no dead-time: back-to-back interactions each produce all three decisions.

The 252-bit message is rebuilt and registered at every clock edge.

Top module: `trig_msg_assembler`

## Requirements
- R1: While reset is asserted, the message is all zeros and both counters are held at zero.
- R2: Without an orbit pulse, the crossing counter advances by one at every edge and returns to 0 after it holds the value on `orbit_len`. The orbit counter does not change.
- R3: An orbit pulse sampled at an edge sets the crossing counter to 0 and increments the orbit counter. The pulse takes priority over the wrap.
- R4: The message registered at an edge carries the crossing counter in bits 11:0 and the orbit counter in bits 43:12, as they stood just before that edge.
- R5: An interaction sampled at edge e produces a class-k decision at edge e+L. L is 31 for class 0, 60 for class 1 and 256 for class 2. Bit 92+24k+d is then set for each detector d whose 2-bit class code `det_class[2d+1:2d]` equals k. Code 3 means no class.
- R6: A detector whose busy flag is high at the decision edge gets no trigger bit in any class at that edge.
- R7: Bits 164+8k to 171+8k hold the event type captured with the interaction that fires class k. They are zero when class k does not fire.
- R8: Bits 91:44 hold the input pattern of the interaction behind the highest-numbered class firing at that edge. They are zero when no class fires.
- R9: Bits 251:188 repeat the spare input sampled at the same edge.
- R10: An interaction on every crossing produces a decision in every class on every crossing once the delays have filled. Nothing is suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_pulse | input | 1 | Start of orbit |
| orbit_len | input | 12 | Last crossing number before the counter wraps |
| interaction | input | 1 | Interaction in this crossing |
| in_mask | input | 48 | Trigger input pattern of this crossing |
| ev_type | input | 8 | Event type code of this crossing |
| det_busy | input | 24 | Per-detector busy flags |
| det_class | input | 48 | 2-bit latency class code per detector |
| spare_in | input | 64 | Free-use message field |
| msg | output | 252 | Assembled trigger message |

## Verification
The bench uses the default latencies of 31, 60 and 256 crossings, so the longest delay line is exercised across its full depth and its pointer wraps. The bench drives orbit lengths of 40, 0 and 4095. The short values produce many wraps in a brief run, and some orbit pulses are timed to fall on the wrap crossing. The 4095 phase reaches the widest crossing-number value. One phase raises an interaction on every crossing and another keeps every detector busy.

// File: rtl/trig_msg_assembler.sv
module trig_msg_assembler #(
  parameter int NDET   = 24,
  parameter int NIN    = 48,
  parameter int NTYP   = 8,
  parameter int NSPARE = 64,
  parameter int ORB_W  = 32,
  parameter int BC_W   = 12,
  parameter int LAT_A  = 31,
  parameter int LAT_B  = 60,
  parameter int LAT_C  = 256,
  localparam int NCLS  = 3,
  localparam int EVW   = ORB_W + BC_W,
  localparam int MSG_W = EVW + NIN + NCLS*NDET + NCLS*NTYP + NSPARE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                orbit_pulse,
  input  logic [BC_W-1:0]     orbit_len,
  input  logic                interaction,
  input  logic [NIN-1:0]      in_mask,
  input  logic [NTYP-1:0]     ev_type,
  input  logic [NDET-1:0]     det_busy,
  input  logic [2*NDET-1:0]   det_class,
  input  logic [NSPARE-1:0]   spare_in,
  output logic [MSG_W-1:0]    msg
);
  localparam int LAT_AB  = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int LAT_MAX = (LAT_AB > LAT_C) ? LAT_AB : LAT_C;
  localparam int AW      = $clog2(LAT_MAX);
  localparam int DEPTH   = 1 << AW;
  localparam int DW      = NIN + NTYP;
  localparam int LAT [NCLS] = '{LAT_A, LAT_B, LAT_C};
  localparam int IM_LO = EVW;
  localparam int DM_LO = IM_LO + NIN;
  localparam int TY_LO = DM_LO + NCLS*NDET;
  localparam int SP_LO = TY_LO + NCLS*NTYP;

  logic [BC_W-1:0]    bc_q;
  logic [ORB_W-1:0]   orb_q;
  logic [LAT_MAX-1:0] ihist;
  logic [AW-1:0]      wp;
  logic [DW-1:0]      ram [DEPTH];

  logic [NCLS-1:0]      fire;
  logic [DW-1:0]        rd [NCLS];
  logic [NCLS*NDET-1:0] det_nx;
  logic [NCLS*NTYP-1:0] typ_nx;
  logic [NIN-1:0]       im_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_q  <= '0;
      orb_q <= '0;
    end else if (orbit_pulse) begin
      bc_q  <= '0;
      orb_q <= orb_q + ORB_W'(1);
    end else if (bc_q == orbit_len) begin
      bc_q  <= '0;
    end else begin
      bc_q  <= bc_q + BC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ihist <= '0;
      wp    <= '0;
    end else begin
      ihist <= {ihist[LAT_MAX-2:0], interaction};
      wp    <= wp + AW'(1);
    end
  end

  always_ff @(posedge clk) ram[wp] <= {ev_type, in_mask};

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    localparam logic [AW-1:0] OFF = AW'(LAT[k] % DEPTH);
    assign fire[k] = ihist[LAT[k]-1];
    assign rd[k]   = ram[wp - OFF];
    assign typ_nx[k*NTYP +: NTYP] = fire[k] ? rd[k][NIN +: NTYP] : '0;
    for (genvar d = 0; d < NDET; d++) begin : g_det
      assign det_nx[k*NDET + d] = fire[k] & (det_class[2*d +: 2] == 2'(k)) & ~det_busy[d];
    end
  end

  assign im_nx = fire[2] ? rd[2][NIN-1:0] :
                 fire[1] ? rd[1][NIN-1:0] :
                 fire[0] ? rd[0][NIN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) msg <= '0;
    else        msg <= {spare_in, typ_nx, det_nx, im_nx, orb_q, bc_q};
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!orbit_pulse && bc_q == orbit_len) |=> (bc_q == '0));

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!orbit_pulse && bc_q != orbit_len) |=> (bc_q == $past(bc_q) + BC_W'(1)) && $stable(orb_q));

  a_r3_orbit_step: assert property (@(posedge clk) disable iff (!rst_n)
    orbit_pulse |=> (bc_q == '0) && (orb_q == $past(orb_q) + ORB_W'(1)));

  a_r9_spare: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (msg[SP_LO +: NSPARE] == $past(spare_in)));

  for (genvar k = 0; k < NCLS; k++) begin : g_chk
    a_r6_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((msg[DM_LO + k*NDET +: NDET] & $past(det_busy)) == '0));
    for (genvar d = 0; d < NDET; d++) begin : g_dchk
      a_r5_class_match: assert property (@(posedge clk) disable iff (!rst_n)
        msg[DM_LO + k*NDET + d] |-> ($past(det_class[2*d +: 2]) == 2'(k)));
    end
  end
endmodule

// File: tb/trig_msg_assembler_bench.sv
module trig_msg_assembler_bench;
  localparam int NDET = 24, NIN = 48, NTYP = 8, NSP = 64;
  localparam int MSG_W = 252, NCYC = 8192, NTOT = 6300;
  localparam int IM_LO = 44, DM_LO = 92, TY_LO = 164, SP_LO = 188;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, orbit_pulse, interaction;
  logic [11:0]       orbit_len;
  logic [NIN-1:0]    in_mask;
  logic [NTYP-1:0]   ev_type;
  logic [NDET-1:0]   det_busy;
  logic [2*NDET-1:0] det_class;
  logic [NSP-1:0]    spare_in;
  logic [MSG_W-1:0]  msg;

  trig_msg_assembler u_trig_msg_assembler (
    .clk(clk), .rst_n(rst_n), .orbit_pulse(orbit_pulse), .orbit_len(orbit_len),
    .interaction(interaction), .in_mask(in_mask), .ev_type(ev_type),
    .det_busy(det_busy), .det_class(det_class), .spare_in(spare_in), .msg(msg));

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit             ih [NCYC];
  logic [NIN-1:0] mh [NCYC];
  logic [NTYP-1:0] th [NCYC];
  int lat [3] = '{31, 60, 256};
  int mbc;
  logic [31:0] morb;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [43:0]        e_ev;
    logic [NIN-1:0]     e_im;
    logic [3*NDET-1:0]  e_dm;
    logic [3*NTYP-1:0]  e_ty;
    logic [NSP-1:0]     e_sp;
    bit                 f [3];
    string              dreq;
    rst_n = 1'b0; orbit_pulse = 1'b0; interaction = 1'b0; orbit_len = 12'd40;
    in_mask = '0; ev_type = '0; det_busy = '0; det_class = '0; spare_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    interaction = 1'b1; orbit_pulse = 1'b1; spare_in = '1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset message", 256'(msg), 256'(0));
    interaction = 1'b0; orbit_pulse = 1'b0;
    rst_n = 1'b1;
    mbc = 0; morb = '0;
    for (int n = 0; n < NTOT; n++) begin
      dreq = "R5/R6 detector field";
      if (n < 800) begin
        orbit_len   = 12'd40;
        interaction = ($urandom % 4) == 0;
        det_busy    = NDET'($urandom);
        orbit_pulse = ((mbc == 40) && (n % 3 == 0)) || (($urandom % 97) == 0);
      end else if (n < 1200) begin
        interaction = 1'b1; det_busy = '0; orbit_pulse = 1'b0;
        dreq = "R10 back-to-back detector field";
      end else if (n < 1600) begin
        interaction = ($urandom % 2) == 0; det_busy = '1;
        orbit_pulse = (mbc == 40);
        dreq = "R6 all busy detector field";
      end else if (n < 1800) begin
        orbit_len = 12'd0; interaction = ($urandom % 3) == 0;
        det_busy = NDET'($urandom); orbit_pulse = ($urandom % 50) == 0;
      end else begin
        orbit_len = 12'd4095; interaction = ($urandom % 5) == 0;
        det_busy = NDET'($urandom) & NDET'($urandom); orbit_pulse = 1'b0;
      end
      in_mask   = {$urandom, $urandom};
      ev_type   = NTYP'($urandom);
      det_class = {$urandom, $urandom};
      spare_in  = {$urandom, $urandom};
      ih[n] = interaction; mh[n] = in_mask; th[n] = ev_type;

      @(posedge clk);
      e_ev = {morb, 12'(mbc)};
      if (orbit_pulse) begin mbc = 0; morb = morb + 1; end
      else if (mbc == int'(orbit_len)) mbc = 0;
      else mbc = mbc + 1;
      for (int k = 0; k < 3; k++) f[k] = (n >= lat[k]) && ih[n - lat[k]];
      e_im = '0;
      for (int k = 0; k < 3; k++) if (f[k]) e_im = mh[n - lat[k]];
      for (int k = 0; k < 3; k++) begin
        e_ty[k*NTYP +: NTYP] = f[k] ? th[n - lat[k]] : '0;
        for (int d = 0; d < NDET; d++)
          e_dm[k*NDET + d] = f[k] && (int'(det_class[2*d +: 2]) == k) && !det_busy[d];
      end
      e_sp = spare_in;

      @(negedge clk);
      chk("R4 event id (R2 R3 counters)", 256'(msg[43:0]), 256'(e_ev));
      chk("R8 input mask field", 256'(msg[IM_LO +: NIN]), 256'(e_im));
      chk(dreq, 256'(msg[DM_LO +: 3*NDET]), 256'(e_dm));
      chk("R7 event type field", 256'(msg[TY_LO +: 3*NTYP]), 256'(e_ty));
      chk("R9 spare field", 256'(msg[SP_LO +: NSP]), 256'(e_sp));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired (R10 progress) act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule